// File: doc/BRIEF.md
# Delayed-Parity Checker with Stretched Error Flag

This block checks even parity over a strap-selected group of input data bits. The parity bit for a data word arrives one clock after the word itself. The block registers the data-side parity and then folds in the late parity bit. Two clock edges after a word is captured, it presents two results on the same edge:

- a partial-parity output, which is the XOR of the selected data bits and the late parity bit;
- an active-low error flag.

Once the flag goes low it stays low for a minimum number of cycles. Two copies can be chained: the partial-parity output of the first drives the parity input of the second, so the second copy's flag covers the bits of both.

Two chip-select inputs, both active low, control a low-power state. While both are high, the partial-parity output does not change. One cycle later, an internal registered copy of that condition also freezes the error flag. An asynchronous active-low reset clears the pipeline, drives the partial-parity output low and drives the flag high.

Top module: `parity_err_checker`

## Requirements
- R1: While `rst_n` is low, `ppo` is 0 and `err_n` is 1, and both take these values as soon as `rst_n` falls, without waiting for a clock edge.
- R2: With `strap_half`=0 and `strap_upper`=0, the checked bits are `din` bit numbers 2, 3, 5, 6 and 8 through 25. Bit number n is `din[n-1]`, and no other `din` bit has any effect on `ppo` or `err_n`.
- R3: With `strap_half`=1 and `strap_upper`=0, the checked bits are bit numbers 2, 3, 5, 6 and 8 through 14 only.
- R4: With `strap_half`=1 and `strap_upper`=1, the checked bits are bit numbers 1 through 6 and 8 through 13 only.
- R5: Take a word captured at edge k and the `par_in` value captured at edge k+1. After edge k+2, `ppo` equals the XOR of that word's checked bits with that `par_in` value, provided chip selects allow the update.
- R6: When the result of R5 is 1 and the error flag is not frozen, `err_n` is low after edge k+2.
- R7: A single isolated parity error holds `err_n` low for exactly 2 cycles.
- R8: A run of N consecutive parity errors, with N of 2 or more, holds `err_n` low for exactly N cycles. After that, `err_n` returns high.
- R9: At any clock edge where `cs_a_n` and `cs_b_n` are both sampled high, `ppo` keeps its value.
- R10: At any clock edge that follows an edge where both chip selects were sampled high, `err_n` keeps its value, and so does its minimum-low count.
- R11: In a cascade, the first copy (straps 1,0) drives the `par_in` of a second copy (straps 1,1), and both copies see the same data. With the inputs held steady, the second copy's `err_n` is low exactly when the checked bits of both copies plus the first copy's `par_in` contain an odd number of ones.
- R12: The strap combination `strap_half`=0, `strap_upper`=1 selects the same bits as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_half | input | 1 | Bit-group strap: 0 selects the wide group, 1 selects a narrow group |
| strap_upper | input | 1 | In narrow mode, selects the group for the second copy of a pair |
| din | input | 25 | Data word; bit number n is din[n-1] |
| par_in | input | 1 | Parity bit for the word captured one edge earlier |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| ppo | output | 1 | Registered partial parity |
| err_n | output | 1 | Active-low parity error flag with minimum-low stretch |

## Verification
Two functions can land on the same cycle: a parity error reaching the flag stage, and the low-power freeze taking effect at that stage. The bench provokes this by toggling the chip selects at random while the parity input is also random, so errors, stretch countdowns and freezes overlap in many phase relations. Each cycle it compares the flag and the partial parity against a model written from R5 to R10. The model decides whether the freeze or the error wins on each edge.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  localparam int unsigned MASK_W = 32;

  typedef enum logic [1:0] {
    MAP_WIDE      = 2'b00,
    MAP_RESERVED  = 2'b01,
    MAP_NARROW_LO = 2'b10,
    MAP_NARROW_HI = 2'b11
  } map_e;

  // Bit number n (1-based) selects mask bit n-1.
  function automatic logic [MASK_W-1:0] group_mask(input map_e m);
    logic [MASK_W-1:0] msk;
    msk = '0;
    for (int n = 1; n <= MASK_W; n++) begin
      unique case (m)
        MAP_NARROW_HI:
          msk[n-1] = (n <= 6) || (n >= 8 && n <= 13);
        MAP_NARROW_LO:
          msk[n-1] = (n == 2) || (n == 3) || (n == 5) || (n == 6) || (n >= 8 && n <= 14);
        default:
          msk[n-1] = (n == 2) || (n == 3) || (n == 5) || (n == 6) || (n >= 8 && n <= 25);
      endcase
    end
    return msk;
  endfunction

endpackage

// File: rtl/pchk_subset.sv
module pchk_subset
  import pchk_pkg::*;
#(
  parameter int unsigned DATA_W = 25
) (
  input  logic [DATA_W-1:0] din,
  input  map_e              map,
  output logic              odd
);

  logic [MASK_W-1:0] full_mask;
  logic [DATA_W-1:0] sel_bits;

  assign full_mask = group_mask(map);

  for (genvar i = 0; i < DATA_W; i++) begin : g_sel
    if (i < MASK_W) begin : g_in
      assign sel_bits[i] = din[i] & full_mask[i];
    end else begin : g_out
      assign sel_bits[i] = 1'b0;
    end
  end

  assign odd = ^sel_bits;

endmodule

// File: rtl/pchk_pipe.sv
module pchk_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic data_odd,
  input  logic par_in,
  input  logic lp_now,
  output logic sum_q,
  output logic ppo
);

  logic odd_q, odd_d;
  logic sum_d;
  logic ppo_q, ppo_d;
  logic ppo_en;

  always_comb begin
    odd_d  = data_odd;
    sum_d  = odd_q ^ par_in;
    ppo_en = ~lp_now;
    ppo_d  = sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= 1'b0;
      sum_q <= 1'b0;
      ppo_q <= 1'b0;
    end else begin
      odd_q <= odd_d;
      sum_q <= sum_d;
      if (ppo_en) begin
        ppo_q <= ppo_d;
      end
    end
  end

  assign ppo = ppo_q;

  AST_PPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lp_now |=> $stable(ppo)); // R9

endmodule

// File: rtl/pchk_errlatch.sv
module pchk_errlatch #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_q,
  input  logic lps_q,
  output logic err_n
);

  localparam int unsigned CNT_W = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic             low_q, low_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             upd_en;

  always_comb begin
    upd_en = ~lps_q;
    low_d  = low_q;
    len_d  = len_q;
    if (sum_q) begin
      low_d = 1'b1;
      if (!low_q) begin
        len_d = CNT_W'(1);
      end else if (len_q != CNT_MAX) begin
        len_d = len_q + 1'b1;
      end
    end else if (low_q && (len_q < CNT_MAX)) begin
      len_d = len_q + 1'b1;
    end else begin
      low_d = 1'b0;
      len_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      len_q <= '0;
    end else if (upd_en) begin
      low_q <= low_d;
      len_q <= len_d;
    end
  end

  assign err_n = ~low_q;

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lps_q && sum_q) |=> !err_n); // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lps_q |=> $stable(err_n)); // R10

  AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n); // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> (!$past(sum_q) && !$past(lps_q))); // R8

endmodule

// File: rtl/parity_err_checker.sv
module parity_err_checker
  import pchk_pkg::*;
#(
  parameter int unsigned DATA_W  = 25,
  parameter int unsigned MIN_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_half,
  input  logic              strap_upper,
  input  logic [DATA_W-1:0] din,
  input  logic              par_in,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  output logic              ppo,
  output logic              err_n
);

  map_e map;
  logic data_odd;
  logic sum_q;
  logic lp_now;
  logic lps_q, lps_d;

  assign map    = map_e'({strap_half, strap_upper});
  assign lp_now = cs_a_n & cs_b_n;

  pchk_subset #(.DATA_W(DATA_W)) u_subset (
    .din  (din),
    .map  (map),
    .odd  (data_odd)
  );

  pchk_pipe u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_odd (data_odd),
    .par_in   (par_in),
    .lp_now   (lp_now),
    .sum_q    (sum_q),
    .ppo      (ppo)
  );

  always_comb begin
    lps_d = lp_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lps_q <= 1'b0;
    end else begin
      lps_q <= lps_d;
    end
  end

  pchk_errlatch #(.MIN_LOW(MIN_LOW)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .sum_q (sum_q),
    .lps_q (lps_q),
    .err_n (err_n)
  );

  AST_LPS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n && cs_b_n && !lps_q && !err_n) |=> ##1 $stable(err_n)); // R10

endmodule

// File: tb/tb_parity_err_checker.sv
`timescale 1ns/1ps
module tb_parity_err_checker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_half, strap_upper;
  logic [24:0] din;
  logic        par_in, cs_a_n, cs_b_n;
  logic        ppo, err_n;
  logic        ppo_b, err_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  parity_err_checker dut (
    .clk(clk), .rst_n(rst_n), .strap_half(strap_half), .strap_upper(strap_upper),
    .din(din), .par_in(par_in), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .ppo(ppo), .err_n(err_n));

  parity_err_checker dut_b (
    .clk(clk), .rst_n(rst_n), .strap_half(1'b1), .strap_upper(1'b1),
    .din(din), .par_in(ppo), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .ppo(ppo_b), .err_n(err_b));

  function automatic bit in_group(bit h, bit u, int n);
    if (h && u) return (n >= 1 && n <= 6) || (n >= 8 && n <= 13);
    if (h)      return n == 2 || n == 3 || n == 5 || n == 6 || (n >= 8 && n <= 14);
    return n == 2 || n == 3 || n == 5 || n == 6 || (n >= 8 && n <= 25);
  endfunction

  function automatic bit grp_par(logic [24:0] d, bit h, bit u);
    bit p = 0;
    for (int n = 1; n <= 25; n++) if (in_group(h, u, n) && d[n-1]) p = ~p;
    return p;
  endfunction

  // Reference model built from R5..R10
  bit m_odd, m_sum, m_lps, m_ppo, m_low;
  int m_len;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_odd <= 0; m_sum <= 0; m_lps <= 0; m_ppo <= 0; m_low <= 0; m_len <= 0;
    end else begin
      m_odd <= grp_par(din, strap_half, strap_upper);
      m_sum <= m_odd ^ par_in;
      m_lps <= cs_a_n & cs_b_n;
      if (!(cs_a_n & cs_b_n)) m_ppo <= m_sum;
      if (!m_lps) begin
        if (m_sum) begin
          m_low <= 1; m_len <= m_low ? m_len + 1 : 1;
        end else if (m_low && m_len < 2) begin
          m_len <= m_len + 1;
        end else begin
          m_low <= 0; m_len <= 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tp, string te, logic [24:0] d, logic p, logic a, logic b);
    @(negedge clk);
    chk(tp, ppo, m_ppo, "ppo");
    chk(te, err_n, ~m_low, "err_n");
    din = d; par_in = p; cs_a_n = a; cs_b_n = b;
  endtask

  task automatic reset_dut(bit h, bit u);
    @(negedge clk);
    rst_n = 0; strap_half = h; strap_upper = u;
    din = '0; par_in = 0; cs_a_n = 0; cs_b_n = 0;
    @(negedge clk);
    chk("R1", ppo, 1'b0, "ppo in reset");
    chk("R1", err_n, 1'b1, "err_n in reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic walk(string tag, bit h, bit u);
    reset_dut(h, u);
    for (int i = 0; i < 25; i++)
      repeat (5) step(tag, tag, 25'(1) << i, 1'b0, 1'b0, 1'b0);
    repeat (5) step(tag, tag, '1, 1'b0, 1'b0, 1'b0);
    repeat (5) step(tag, tag, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 0; strap_half = 0; strap_upper = 0;
    din = '0; par_in = 0; cs_a_n = 0; cs_b_n = 0;

    // R2, R3, R4, R12: walking one over every data bit per strap setting
    walk("R2", 1'b0, 1'b0);
    walk("R3", 1'b1, 1'b0);
    walk("R4", 1'b1, 1'b1);
    walk("R12", 1'b0, 1'b1);

    // R5, R6: random data and parity
    reset_dut(1'b0, 1'b0);
    repeat (400) step("R5", "R6", 25'($urandom), 1'($urandom), 1'b0, 1'b0);

    // R7: isolated errors among good parity
    reset_dut(1'b1, 1'b1);
    for (int t = 0; t < 25; t++) begin
      repeat (4) step("R5", "R7", 25'($urandom), grp_par(din, 1'b1, 1'b1), 1'b0, 1'b0);
      step("R5", "R7", 25'($urandom), ~grp_par(din, 1'b1, 1'b1), 1'b0, 1'b0);
    end
    repeat (6) step("R5", "R7", 25'($urandom), grp_par(din, 1'b1, 1'b1), 1'b0, 1'b0);

    // R8: error bursts of length 2..6
    reset_dut(1'b0, 1'b0);
    for (int nb = 2; nb <= 6; nb++) begin
      repeat (5) step("R5", "R8", 25'($urandom), grp_par(din, 1'b0, 1'b0), 1'b0, 1'b0);
      repeat (nb) step("R5", "R8", 25'($urandom), ~grp_par(din, 1'b0, 1'b0), 1'b0, 1'b0);
    end
    repeat (6) step("R5", "R8", 25'($urandom), grp_par(din, 1'b0, 1'b0), 1'b0, 1'b0);

    // R9, R10: random chip selects overlapping with errors and stretch
    reset_dut(1'b1, 1'b0);
    repeat (600) step("R9", "R10", 25'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    repeat (6) step("R9", "R10", 25'($urandom), 1'b1, 1'b1, 1'b1);

    // R1: reset in the middle of an error
    repeat (3) step("R5", "R6", 25'h1FFFFFF, 1'b1, 1'b0, 1'b0);
    repeat (4) step("R5", "R6", 25'h0000002, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1", err_n, 1'b0, "err_n low before reset");
    #0.5 rst_n = 0;
    #0.2;
    chk("R1", err_n, 1'b1, "err_n on async reset");
    chk("R1", ppo, 1'b0, "ppo on async reset");
    @(negedge clk);
    rst_n = 1;

    // R11: cascade of two copies, inputs held steady
    reset_dut(1'b1, 1'b0);
    for (int t = 0; t < 40; t++) begin
      logic [24:0] dv;
      logic        pv;
      dv = 25'($urandom);
      pv = 1'($urandom);
      repeat (9) step("R11", "R11", dv, pv, 1'b0, 1'b0);
      @(negedge clk);
      chk("R11", err_b, ~(grp_par(dv, 1'b1, 1'b0) ^ pv ^ grp_par(dv, 1'b1, 1'b1)), "cascade err_n");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule